// File: doc/BRIEF.md
# Charge Command Watchdog Timer

This block stops charging when the host stops refreshing the charge setpoints. It counts one-second ticks. Every accepted write to the charge-voltage or charge-current setpoint starts the count again. If the count reaches the window length picked by a 2-bit period code, the block raises an expired level, and with it a charge-suspend request.

The setpoint registers live outside this block and are never touched. A suspend only gates charging. Charging resumes on one of three events:
- a fresh write to either of the two setpoints;
- moving the period code to the disabled value;
- moving the period code to a different enabled window.

The tick arrives on a one-cycle strobe from an external prescaler. A bench can drive that strobe on every cycle to shorten time.

Top module: `charge_watchdog`

## Requirements
- R1: After reset is released, `expired` and `charge_suspend` are both 0.
- R2: The period code on `period_sel` sets the window as follows: 2'b01 gives 44 ticks, 2'b10 gives 88 ticks and 2'b11 gives 175 ticks. `expired` rises on the cycle after the window's final tick is sampled, and not one tick earlier.
- R3: Right after reset with `period_sel` at 2'b11, the first window is a full 175 ticks, counted from reset. No write is needed to arm it.
- R4: A cycle with `wr_volt` or `wr_curr` high sets the count back to zero. The next expiry then comes a full window of ticks after that write.
- R5: `expired` is a level. Once set, it stays high through any number of further ticks until a resume event occurs.
- R6: While expired, a write pulse on `wr_volt` or `wr_curr` clears `expired` on the next cycle and starts a new full window.
- R7: With `period_sel` at 2'b00 the watchdog is off. A cycle with code 2'b00 clears `expired` on the next cycle. No tick can set `expired` while the code stays 2'b00, and write pulses have no visible effect.
- R8: A change of `period_sel` from one enabled code to another sets the count to zero and clears `expired`. The next expiry then comes after the new code's full window.
- R9: When a write pulse and a tick arrive in the same cycle, the write wins. That tick is not counted.
- R10: `charge_suspend` is high exactly when `expired` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_sel | input | 2 | Window code: 00 off, 01 short, 10 medium, 11 long |
| wr_volt | input | 1 | One-cycle pulse for an accepted charge-voltage write |
| wr_curr | input | 1 | One-cycle pulse for an accepted charge-current write |
| sec_tick | input | 1 | One-cycle strobe per second from the prescaler |
| expired | output | 1 | Watchdog window elapsed (level) |
| charge_suspend | output | 1 | Request to halt charging |

## Verification
The hardest cases to reach are the edges of the count. One is a restart that lands exactly on the tick that would have completed the window. Another is a period change that arrives while the count already exceeds the new, shorter window. The bench drives the tick on every cycle during directed runs, so it can place a write or a code change on a chosen tick number. A long random phase then mixes sparse writes and code changes with a tick rate of one in two, and compares every cycle against a bench model of the window.

// File: rtl/charge_watchdog.sv
module charge_watchdog #(
  parameter int P_SHORT = 44,
  parameter int P_MID   = 88,
  parameter int P_LONG  = 175,
  localparam int CW     = $clog2(P_LONG + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] period_sel,
  input  logic       wr_volt,
  input  logic       wr_curr,
  input  logic       sec_tick,
  output logic       expired,
  output logic       charge_suspend
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic [1:0]    sel_q;
  logic          enabled;
  logic          restart;
  logic          last_tick;

  always_comb begin
    case (period_sel)
      2'b01:   limit = CW'(P_SHORT);
      2'b10:   limit = CW'(P_MID);
      default: limit = CW'(P_LONG);
    endcase
  end

  assign enabled   = period_sel != 2'b00;
  assign restart   = wr_volt | wr_curr | (period_sel != sel_q);
  assign last_tick = sec_tick & ~expired & (cnt + CW'(1) == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
      sel_q   <= 2'b11;
    end else begin
      sel_q <= period_sel;
      if (!enabled || restart) begin
        cnt     <= '0;
        expired <= 1'b0;
      end else if (sec_tick && !expired) begin
        cnt <= cnt + CW'(1);
        if (last_tick) expired <= 1'b1;
      end
    end
  end

  assign charge_suspend = expired;

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_volt || wr_curr) |=> !expired); // R6
  AST_OFF_NEVER_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (period_sel == 2'b00) |=> !expired); // R7
  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(sec_tick)); // R2
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !wr_volt && !wr_curr && period_sel == sel_q && enabled) |=> expired); // R5
  AST_SUSPEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> charge_suspend); // R10

endmodule

// File: tb/test_charge_watchdog.sv
module test_charge_watchdog;
  logic clk = 0, rst_n = 0;
  logic [1:0] period_sel = 2'b11;
  logic wr_volt = 0, wr_curr = 0, sec_tick = 0;
  logic expired, charge_suspend;

  int checks = 0, errors = 0, cycles = 0;
  int m_cnt = 0;
  bit m_exp = 0;
  logic [1:0] m_psel = 2'b11;

  always #4 clk = ~clk;

  charge_watchdog i_charge_watchdog (
    .clk(clk), .rst_n(rst_n), .period_sel(period_sel), .wr_volt(wr_volt),
    .wr_curr(wr_curr), .sec_tick(sec_tick), .expired(expired),
    .charge_suspend(charge_suspend));

  function automatic int limit_of(logic [1:0] s);
    return (s == 2'b01) ? 44 : (s == 2'b10) ? 88 : 175;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic model_update();
    if (period_sel == 2'b00 || wr_volt || wr_curr || period_sel != m_psel) begin
      m_cnt = 0; m_exp = 0;
    end else if (sec_tick && !m_exp) begin
      m_cnt++;
      if (m_cnt == limit_of(period_sel)) m_exp = 1;
    end
    m_psel = period_sel;
  endtask

  task automatic step(logic [1:0] s, bit v, bit c, bit t);
    @(negedge clk);
    period_sel = s; wr_volt = v; wr_curr = c; sec_tick = t;
    @(posedge clk);
    model_update();
    #2;
  endtask

  task automatic ticks(logic [1:0] s, int n);
    for (int k = 0; k < n; k++) step(s, 0, 0, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd12345;
    void'($urandom(seed));
    #20 rst_n = 1;
    #1;
    chk("R1 expired after reset", expired, 0);
    chk("R1 suspend after reset", charge_suspend, 0);

    ticks(2'b11, 174);
    chk("R3 no expiry at tick 174", expired, 0);
    ticks(2'b11, 1);
    chk("R3 expiry at tick 175", expired, 1);
    chk("R10 suspend follows", charge_suspend, 1);
    ticks(2'b11, 30);
    chk("R5 level holds", expired, 1);

    step(2'b11, 1, 0, 0);
    chk("R6 volt write resumes", expired, 0);
    chk("R10 suspend drops", charge_suspend, 0);
    step(2'b01, 0, 0, 0);
    ticks(2'b01, 43);
    chk("R2 short window tick 43", expired, 0);
    ticks(2'b01, 1);
    chk("R2 short window tick 44", expired, 1);

    step(2'b01, 0, 1, 1);
    chk("R6 curr write resumes", expired, 0);
    ticks(2'b01, 20);
    step(2'b01, 1, 0, 1);
    chk("R9 write beats tick", expired, 0);
    ticks(2'b01, 43);
    chk("R4 restart: tick 43 after write", expired, 0);
    ticks(2'b01, 1);
    chk("R4 restart: tick 44 after write", expired, 1);

    step(2'b10, 0, 0, 1);
    chk("R8 code change clears", expired, 0);
    ticks(2'b10, 87);
    chk("R2 mid window tick 87", expired, 0);
    ticks(2'b10, 1);
    chk("R2 mid window tick 88", expired, 1);

    ticks(2'b00, 1);
    chk("R7 disable clears expiry", expired, 0);
    ticks(2'b00, 300);
    chk("R7 no expiry while off", expired, 0);
    step(2'b00, 1, 1, 1);
    chk("R7 write while off ignored", expired, 0);

    step(2'b10, 0, 0, 0);
    ticks(2'b10, 60);
    step(2'b01, 0, 0, 0);
    chk("R8 shrink clears count", expired, 0);
    ticks(2'b01, 43);
    chk("R8 new window tick 43", expired, 0);
    ticks(2'b01, 1);
    chk("R8 new window tick 44", expired, 1);

    for (int n = 0; n < 6000; n++) begin
      logic [1:0] s = period_sel;
      if ($urandom_range(599) == 0) s = 2'($urandom_range(3));
      step(s, $urandom_range(149) == 0, $urandom_range(149) == 0, $urandom_range(1) == 1);
      chk("R4 random expired vs model", expired, m_exp);
      chk("R10 random suspend vs model", charge_suspend, m_exp);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule